// File: doc/BRIEF.md
# Receive word queue with deferred service request

This block sits between a receive deserializer and a slower software-driven consumer. The deserializer hands each finished 16-bit word to a single holding register. That register runs on the receive clock. The queue itself runs on the system clock. Crossing between the two is a toggle handshake: the holding register flips a request line, two flops carry it into the system domain, and an acknowledge toggle returns the same way. The word stays in the holding register until the system side has seen the request and the queue has a free slot.

The consumer is woken through a service-request output. That output is raised only while two or more words are queued. As a result, the last word of every packet, which is the trailing checksum, is never requested and stays behind. This costs one word of usable depth. A full flag is exported for transmit start logic. A synchronous flush empties the queue and discards any word waiting in the holding register.

Back-pressure rules: on the receive side a word moves when `in_valid` and `in_ready` are both high at a rising `rclk` edge. `in_ready` stays low from that edge until the word has been written into the queue. While `in_valid` is high, the producer must keep `in_data` unchanged until the word is taken. The consumer side is a plain pop strobe. A pop that finds the queue empty does nothing.

Top module: `rx_word_queue`

## Requirements
- R1: After reset the queue is empty, `count` is 0, `full` and `svc_req` are low, and `in_ready` is high.
- R2: A word is taken into the holding register when `in_valid` and `in_ready` are high at a rising `rclk` edge. `in_ready` then stays low, and the held word stays unchanged, until the word has moved into the queue. After that `in_ready` returns high.
- R3: Words leave the queue in the order they were taken, with all 16 bits unchanged.
- R4: `count` never exceeds DEPTH (16), and `full` is high exactly when `count` equals DEPTH. With the queue full, a held word waits, with `in_ready` low, and enters after the next pop.
- R5: `svc_req` is high exactly when `count` is 2 or more. A single queued word never raises it.
- R6: A pop while the queue is not empty lowers `count` by one. From the cycle after the pop, `rd_data` shows the oldest word.
- R7: A pop while the queue is empty leaves `count` unchanged, and `rd_data` keeps the last word read.
- R8: When a pop and a write from the holding register fall in the same `sclk` cycle, both take effect and `count` is unchanged. Across any overlap, the final count equals the words written minus the words popped.
- R9: `flush` high at a rising `sclk` edge empties the queue by the next cycle. A word waiting in the holding register at that time is discarded, and `in_ready` then returns high.
- R10: When `flush` coincides with a pop or a pending write, the flush wins: the queue ends empty and `rd_data` is not updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rclk | input | 1 | Receive-domain clock |
| rrst_n | input | 1 | Receive-domain reset, active low |
| in_valid | input | 1 | Deserializer offers a finished word |
| in_data | input | 16 | Offered word |
| in_ready | output | 1 | Holding register is free |
| sclk | input | 1 | System clock |
| srst_n | input | 1 | System-domain reset, active low |
| flush | input | 1 | Synchronous clear of queue and holding register |
| pop | input | 1 | Consumer removes the oldest word |
| rd_data | output | 16 | Last word removed by a pop |
| count | output | 5 | Words currently queued |
| empty | output | 1 | Queue holds no word |
| full | output | 1 | Queue holds DEPTH words |
| svc_req | output | 1 | Service request, two or more words queued |

## Verification
The write of a handed-off word and a consumer pop can land in the same system cycle. Because the handshake latency across the clock boundary is not known to the producer, the bench pre-loads the queue, starts a hand-off, and opens a three-cycle pop window at every start offset from zero to ten system cycles. Some of these windows straddle the write cycle. In every case the bench requires the final count to equal pre-load plus one minus three, and the remaining words to come out in acceptance order. Flush against a pending write and a simultaneous pop is judged the same way, with a full queue and a word held back.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int unsigned WORD_W_DEF = 16;
  localparam int unsigned DEPTH_DEF  = 16;
  localparam int unsigned SYNC_DEF   = 2;
  localparam int unsigned SVC_LEVEL  = 2;

  typedef enum logic {
    HOLD_FREE = 1'b0,
    HOLD_BUSY = 1'b1
  } hold_state_t;
endpackage

// File: rtl/rxq_sync.sv
module rxq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rxq_hold.sv
module rxq_hold
  import rxq_pkg::*;
#(
  parameter int unsigned WORD_W = WORD_W_DEF,
  parameter int unsigned SYNC_N = SYNC_DEF
) (
  input  logic              rclk,
  input  logic              rrst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  input  logic              ack_tgl,
  output logic              req_tgl,
  output logic [WORD_W-1:0] hold_word
);
  hold_state_t state;
  logic        ack_seen;
  logic        take;

  rxq_sync #(.STAGES(SYNC_N)) u_ack_sync (
    .clk  (rclk),
    .rst_n(rrst_n),
    .d    (ack_tgl),
    .q    (ack_seen)
  );

  assign in_ready = (state == HOLD_FREE);
  assign take     = in_valid && in_ready;

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      state     <= HOLD_FREE;
      req_tgl   <= 1'b0;
      hold_word <= '0;
    end else begin
      case (state)
        HOLD_FREE: begin
          if (take) begin
            hold_word <= in_data;
            req_tgl   <= ~req_tgl;
            state     <= HOLD_BUSY;
          end
        end
        HOLD_BUSY: begin
          if (ack_seen == req_tgl) state <= HOLD_FREE;
        end
        default: state <= HOLD_FREE;
      endcase
    end
  end
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic              sclk,
  input  logic              srst_n,
  input  logic              flush,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              pop,
  output logic [WORD_W-1:0] rd_data,
  output logic [CW-1:0]     count,
  output logic              empty,
  output logic              full
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_P  = AW'(DEPTH - 1);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic              do_pop, do_wr;

  assign empty  = (count == '0);
  assign full   = (count == DEPTH_C);
  assign do_pop = pop && !empty && !flush;
  assign do_wr  = wr_en && !full && !flush;

  always_ff @(posedge sclk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge sclk or negedge srst_n) begin
    if (!srst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      rd_data <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_wr)  wr_ptr <= (wr_ptr == LAST_P) ? '0 : wr_ptr + 1'b1;
      if (do_pop) begin
        rd_ptr  <= (rd_ptr == LAST_P) ? '0 : rd_ptr + 1'b1;
        rd_data <= mem[rd_ptr];
      end
      case ({do_wr, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/rx_word_queue.sv
module rx_word_queue
  import rxq_pkg::*;
#(
  parameter int unsigned WORD_W = WORD_W_DEF,
  parameter int unsigned DEPTH  = DEPTH_DEF,
  parameter int unsigned SYNC_N = SYNC_DEF,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic              rclk,
  input  logic              rrst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  input  logic              sclk,
  input  logic              srst_n,
  input  logic              flush,
  input  logic              pop,
  output logic [WORD_W-1:0] rd_data,
  output logic [CW-1:0]     count,
  output logic              empty,
  output logic              full,
  output logic              svc_req
);
  logic              req_tgl, req_seen, ack_tgl;
  logic [WORD_W-1:0] hold_word;
  logic              pending, retire, wr_en;

  rxq_hold #(.WORD_W(WORD_W), .SYNC_N(SYNC_N)) u_hold (
    .rclk     (rclk),
    .rrst_n   (rrst_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_ready (in_ready),
    .ack_tgl  (ack_tgl),
    .req_tgl  (req_tgl),
    .hold_word(hold_word)
  );

  rxq_sync #(.STAGES(SYNC_N)) u_req_sync (
    .clk  (sclk),
    .rst_n(srst_n),
    .d    (req_tgl),
    .q    (req_seen)
  );

  // A word is pending while the synchronized request differs from our ack.
  assign pending = (req_seen != ack_tgl);
  // Flush retires a pending word without storing it.
  assign retire  = pending && (flush || !full);
  assign wr_en   = pending && !flush && !full;

  always_ff @(posedge sclk or negedge srst_n) begin
    if (!srst_n)     ack_tgl <= 1'b0;
    else if (retire) ack_tgl <= ~ack_tgl;
  end

  rxq_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
    .sclk   (sclk),
    .srst_n (srst_n),
    .flush  (flush),
    .wr_en  (wr_en),
    .wr_data(hold_word),
    .pop    (pop),
    .rd_data(rd_data),
    .count  (count),
    .empty  (empty),
    .full   (full)
  );

  assign svc_req = (count >= CW'(SVC_LEVEL));
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input logic              rclk,
  input logic              rrst_n,
  input logic              sclk,
  input logic              srst_n,
  input logic              flush,
  input logic              pop,
  input logic              wr_en,
  input logic [CW-1:0]     count,
  input logic              empty,
  input logic              full,
  input logic              svc_req,
  input logic [WORD_W-1:0] rd_data,
  input logic              in_ready,
  input logic [WORD_W-1:0] hold_word
);
  assert_count_bound_R4: assert property (@(posedge sclk) disable iff (!srst_n)
    count <= CW'(DEPTH));

  assert_no_overflow_R4: assert property (@(posedge sclk) disable iff (!srst_n)
    full |-> !wr_en);

  assert_svc_nonempty_R5: assert property (@(posedge sclk) disable iff (!srst_n)
    svc_req |-> !empty);

  assert_svc_single_R5: assert property (@(posedge sclk) disable iff (!srst_n)
    (count == CW'(1)) |-> !svc_req);

  assert_empty_pop_R7: assert property (@(posedge sclk) disable iff (!srst_n)
    (pop && empty && !flush && !wr_en) |=> ($stable(count) && $stable(rd_data)));

  assert_flush_clears_R9: assert property (@(posedge sclk) disable iff (!srst_n)
    flush |=> (empty && (count == '0)));

  assert_flush_no_read_R10: assert property (@(posedge sclk) disable iff (!srst_n)
    flush |=> $stable(rd_data));

  assert_unit_step_R8: assert property (@(posedge sclk) disable iff (!srst_n)
    !flush |=> ((count == $past(count)) || (count == $past(count) + 1'b1) ||
                (count + 1'b1 == $past(count))));

  assert_hold_stable_R2: assert property (@(posedge rclk) disable iff (!rrst_n)
    !in_ready |=> $stable(hold_word));
endmodule

bind rx_word_queue rxq_checker #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_chk (
  .rclk     (rclk),
  .rrst_n   (rrst_n),
  .sclk     (sclk),
  .srst_n   (srst_n),
  .flush    (flush),
  .pop      (pop),
  .wr_en    (wr_en),
  .count    (count),
  .empty    (empty),
  .full     (full),
  .svc_req  (svc_req),
  .rd_data  (rd_data),
  .in_ready (in_ready),
  .hold_word(hold_word)
);

// File: tb/rx_word_queue_tb_top.sv
module rx_word_queue_tb_top;
  localparam int W = 16;
  localparam int D = 16;

  logic rclk = 1'b0, sclk = 1'b0;
  logic rrst_n = 1'b0, srst_n = 1'b0;
  logic in_valid = 1'b0, flush = 1'b0, pop = 1'b0;
  logic [W-1:0] in_data = '0;
  logic in_ready, empty, full, svc_req;
  logic [W-1:0] rd_data;
  logic [4:0] count;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 sclk = ~sclk;
  always #15 rclk = ~rclk;

  rx_word_queue dut_i (
    .rclk(rclk), .rrst_n(rrst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .sclk(sclk), .srst_n(srst_n), .flush(flush),
    .pop(pop), .rd_data(rd_data), .count(count), .empty(empty),
    .full(full), .svc_req(svc_req)
  );

  function automatic logic [W-1:0] word_of(int grp, int idx);
    return W'((grp * 16'h0917) ^ (idx * 16'h1357) ^ 16'hA5C3);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(logic [W-1:0] v);
    @(negedge rclk);
    while (!in_ready) @(negedge rclk);
    in_valid = 1'b1;
    in_data  = v;
    @(negedge rclk);
    in_valid = 1'b0;
  endtask

  task automatic do_pop();
    @(negedge sclk);
    pop = 1'b1;
    @(negedge sclk);
    pop = 1'b0;
  endtask

  task automatic settle();
    repeat (12) @(negedge sclk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge sclk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    repeat (4) @(negedge sclk);
    rrst_n = 1'b1;
    srst_n = 1'b1;
    settle();
    // R1 reset state
    check(count == 0, "R1 count", count, 0);
    check(empty && !full, "R1 flags", {empty, full}, 2'b10);
    check(!svc_req, "R1 svc_req", svc_req, 0);
    check(in_ready, "R1 in_ready", in_ready, 1);

    // Sweep of fill levels 0..D+1 (R2 R3 R4 R5 R6 R7)
    for (int n = 0; n <= D + 1; n++) begin
      int exp_cnt;
      exp_cnt = (n > D) ? D : n;
      for (int i = 0; i < n; i++) push(word_of(n, i));
      settle();
      check(count == exp_cnt, "R4 count after fill", count, exp_cnt);
      check(full == (exp_cnt == D), "R4 full flag", full, exp_cnt == D);
      check(svc_req == (exp_cnt >= 2), "R5 svc_req level", svc_req, exp_cnt >= 2);
      check(in_ready == (n <= D), "R2 in_ready while held", in_ready, n <= D);
      for (int i = 0; i < n; i++) begin
        do_pop();
        check(rd_data == word_of(n, i), "R3 R6 pop order", rd_data, word_of(n, i));
      end
      settle();
      check(count == 0 && empty, "R6 drained", count, 0);
      check(in_ready, "R2 in_ready after drain", in_ready, 1);
      if (n > 0) begin
        do_pop();
        check(count == 0, "R7 empty pop count", count, 0);
        check(rd_data == word_of(n, n - 1), "R7 empty pop data", rd_data, word_of(n, n - 1));
      end
    end

    // R8: pop window against a hand-off, swept over start offsets
    for (int off = 0; off <= 10; off++) begin
      for (int i = 0; i < 5; i++) push(word_of(100 + off, i));
      settle();
      fork
        push(word_of(100 + off, 5));
        begin
          repeat (off) @(negedge sclk);
          pop = 1'b1;
          repeat (3) @(negedge sclk);
          pop = 1'b0;
        end
      join
      settle();
      check(count == 3, "R8 overlap count", count, 3);
      check(rd_data == word_of(100 + off, 2), "R8 last popped", rd_data, word_of(100 + off, 2));
      for (int i = 3; i < 6; i++) begin
        do_pop();
        check(rd_data == word_of(100 + off, i), "R8 R3 order after overlap", rd_data, word_of(100 + off, i));
      end
      settle();
    end

    // R9 R10: flush with a pending held word and a simultaneous pop
    for (int i = 0; i <= D; i++) push(word_of(200, i));
    settle();
    check(full && !in_ready, "R4 full with held word", {full, in_ready}, 2'b10);
    do_pop();
    check(rd_data == word_of(200, 0), "R6 pop from full", rd_data, word_of(200, 0));
    settle();
    check(full, "R4 held word enters after pop", full, 1);
    for (int i = 0; i <= D; i++) ; // no-op spacer
    push(word_of(201, 0));
    settle();
    check(!in_ready, "R2 held while full", in_ready, 0);
    @(negedge sclk);
    flush = 1'b1;
    pop   = 1'b1;
    @(negedge sclk);
    flush = 1'b0;
    pop   = 1'b0;
    check(count == 0 && empty, "R9 flush empties", count, 0);
    check(rd_data == word_of(200, 0), "R10 flush beats pop", rd_data, word_of(200, 0));
    settle();
    check(in_ready, "R9 held word released", in_ready, 1);
    check(count == 0, "R9 held word discarded", count, 0);
    push(word_of(202, 0));
    settle();
    check(count == 1 && !svc_req, "R5 single word no request", {count, svc_req}, 2);
    do_pop();
    check(rd_data == word_of(202, 0), "R9 queue usable after flush", rd_data, word_of(202, 0));

    // R9 partial flush
    for (int i = 0; i < 4; i++) push(word_of(203, i));
    settle();
    @(negedge sclk);
    flush = 1'b1;
    @(negedge sclk);
    flush = 1'b0;
    check(count == 0 && !svc_req, "R9 partial flush", count, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule